// File: doc/BRIEF.md
# Monitor Sense Latch Register

This block samples three per-channel analog comparator results (red, green and blue) and holds them, together with a combined active-low monitor-sense output, for diagnostic use by the host. The comparator results arrive as synchronous digital levels. They are captured only when the chosen blanking signal goes from high to low. A mode input picks that signal from two candidates: the system blank and the VGA-style blank. The block registers the chosen blank and compares it with the value it held one cycle earlier to find the falling edge.

The host reaches the block through an 8-bit indexed interface with a single-cycle write strobe and a combinational read path. A status register at index 0x3A returns the latched channel bits and a disable control. An identification register at index 0x3F always returns a fixed code. When software sets the disable bit, no new results are captured, the channel bits read as zero and the sense output stays high.

Top module: `sense_latch`

## Requirements
- R1: After reset, the status register at index 0x3A reads 0x00 (enabled, no channel above threshold) and `sense_n` is 1.
- R2: On a falling edge of the selected blank, seen at the clock edge where the registered blank is 1 and the live selected blank is 0, the comparator inputs are captured into status bit 2 (red), bit 1 (green) and bit 0 (blue), each 1 for a channel above threshold. The captured value can be read immediately after that edge.
- R3: While the function is enabled, `sense_n` is 0 exactly when at least one latched channel bit is 1, and 1 otherwise. It changes at the same edge as the channel bits.
- R4: Comparator changes at any other time leave the status register and `sense_n` unchanged. This includes changes while blank is steady high, steady low, or rising.
- R5: `blank_sel` = 0 uses `sys_blank` and `blank_sel` = 1 uses `vga_blank`. Edges on the blank that is not selected have no effect.
- R6: Writing index 0x3A with bit 7 = 1 disables the function. Status then reads 0x80, `sense_n` is 1, and falling edges capture nothing. Writing bit 7 = 0 re-enables it, and the channel bits stay 0 until the next falling edge.
- R7: Status bits 6 to 3 always read 0, whatever value was written. Writes never change bits 2 to 0.
- R8: Index 0x3F always reads 0x26, and writes to it have no effect on any register.
- R9: A read of any index other than 0x3A and 0x3F returns 0x00.
- R10: When a write to 0x3A and a falling edge fall in the same cycle, a write of bit 7 = 1 wins: nothing is captured and the bits are cleared. Capture is gated by the disable value held before that edge, so a write of bit 7 = 0 to a disabled block does not capture in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_blank | input | 1 | System blanking signal, synchronous |
| vga_blank | input | 1 | VGA-style blanking signal, synchronous |
| blank_sel | input | 1 | Blank source select: 0 system, 1 VGA |
| cmp_red | input | 1 | Red comparator result, 1 when above threshold |
| cmp_grn | input | 1 | Green comparator result |
| cmp_blu | input | 1 | Blue comparator result |
| host_idx | input | 8 | Register index for reads and writes |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_idx`, combinational |
| sense_n | output | 1 | Monitor sense, 0 when any latched channel is above threshold |

## Verification
A host write to the status register and a falling edge of the selected blank can land on the same clock edge. The bench provokes this by dropping the blank in the same cycle that it raises the write strobe. It does this once while enabled with a write of bit 7 = 1, and once while disabled with a write of bit 7 = 0. It judges the result by the status value read after that edge and by `sense_n`. A behavioural model applies the priority rule and is compared with the design on every clock, so a collision inside the random-looking directed stimulus is also checked.

// File: rtl/sense_latch.sv
module sense_latch #(
  parameter logic [7:0] STATUS_IDX = 8'h3A,
  parameter logic [7:0] IDENT_IDX  = 8'h3F,
  parameter logic [7:0] IDENT_VAL  = 8'h26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_blank,
  input  logic       vga_blank,
  input  logic       blank_sel,
  input  logic       cmp_red,
  input  logic       cmp_grn,
  input  logic       cmp_blu,
  input  logic [7:0] host_idx,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       sense_n
);

  logic       blank_now;
  logic       blank_q;
  logic       blank_fall;
  logic       stat_wr;
  logic       off_q;
  logic [2:0] chan_q;
  logic       sense_q;

  assign blank_now  = blank_sel ? vga_blank : sys_blank;
  assign blank_fall = blank_q & ~blank_now;
  assign stat_wr    = host_wr && (host_idx == STATUS_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b0;
    else        blank_q <= blank_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (stat_wr) off_q <= host_wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= 3'b000;
      sense_q <= 1'b1;
    end else if (stat_wr && host_wdata[7]) begin
      chan_q  <= 3'b000;
      sense_q <= 1'b1;
    end else if (blank_fall && !off_q) begin
      chan_q  <= {cmp_red, cmp_grn, cmp_blu};
      sense_q <= ~(cmp_red | cmp_grn | cmp_blu);
    end
  end

  assign sense_n = off_q | sense_q;

  always_comb begin
    if (host_idx == STATUS_IDX)     host_rdata = {off_q, 4'b0000, chan_q};
    else if (host_idx == IDENT_IDX) host_rdata = IDENT_VAL;
    else                            host_rdata = 8'h00;
  end

endmodule

module sense_latch_chk #(
  parameter logic [7:0] STATUS_IDX = 8'h3A,
  parameter logic [7:0] IDENT_IDX  = 8'h3F,
  parameter logic [7:0] IDENT_VAL  = 8'h26
) (
  input logic       clk,
  input logic       rst_n,
  input logic       blank_fall,
  input logic       stat_wr,
  input logic       off_q,
  input logic [2:0] chan_q,
  input logic [7:0] host_idx,
  input logic [7:0] host_rdata,
  input logic       sense_n
);

  assert_sense_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !off_q |-> (sense_n == ~|chan_q));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_fall && !stat_wr) |=> $stable(chan_q));

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> (chan_q == 3'b000 && sense_n));

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idx == STATUS_IDX) |-> (host_rdata[6:3] == 4'b0000));

  assert_ident_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idx == IDENT_IDX) |-> (host_rdata == IDENT_VAL));

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idx != STATUS_IDX && host_idx != IDENT_IDX) |-> (host_rdata == 8'h00));

  assert_off_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && blank_fall && $past(1'b1)) |=> (chan_q == 3'b000 || !off_q));

endmodule

bind sense_latch sense_latch_chk #(
  .STATUS_IDX(STATUS_IDX), .IDENT_IDX(IDENT_IDX), .IDENT_VAL(IDENT_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blank_fall(blank_fall), .stat_wr(stat_wr),
  .off_q(off_q), .chan_q(chan_q), .host_idx(host_idx),
  .host_rdata(host_rdata), .sense_n(sense_n)
);

// File: tb/tb_sense_latch.sv
module tb_sense_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_blank = 1'b0, vga_blank = 1'b0, blank_sel = 1'b0;
  logic       cmp_red = 1'b0, cmp_grn = 1'b0, cmp_blu = 1'b0;
  logic [7:0] host_idx = 8'h00;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       sense_n;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  bit       m_bq = 0, m_off = 0, m_sense = 1;
  bit [2:0] m_chan = 0;

  always #4 clk = ~clk;

  sense_latch dut (
    .clk(clk), .rst_n(rst_n), .sys_blank(sys_blank), .vga_blank(vga_blank),
    .blank_sel(blank_sel), .cmp_red(cmp_red), .cmp_grn(cmp_grn), .cmp_blu(cmp_blu),
    .host_idx(host_idx), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .sense_n(sense_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bq = 0; m_off = 0; m_chan = 0; m_sense = 1;
    end else begin
      bit sel, fall, old_off, wr_stat;
      sel = blank_sel ? vga_blank : sys_blank;
      fall = m_bq && !sel;
      old_off = m_off;
      wr_stat = host_wr && host_idx == 8'h3A;
      if (wr_stat) m_off = host_wdata[7];
      if (wr_stat && host_wdata[7]) begin
        m_chan = 0; m_sense = 1;
      end else if (fall && !old_off) begin
        m_chan = {cmp_red, cmp_grn, cmp_blu};
        m_sense = (m_chan == 0);
      end
      m_bq = sel;
    end
  end

  function automatic [7:0] exp_read(input [7:0] idx);
    if (idx == 8'h3A) return {m_off, 4'b0000, m_chan};
    if (idx == 8'h3F) return 8'h26;
    return 8'h00;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (host_rdata !== exp_read(host_idx) || sense_n !== (m_off | m_sense)) begin
      bad++;
      $display("FAIL %s model: rdata=%h sense_n=%b expected rdata=%h sense_n=%b",
               cur_req, host_rdata, sense_n, exp_read(host_idx), m_off | m_sense);
    end
  end

  task automatic chk(input string req, input [7:0] got, input [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input [7:0] idx, input [7:0] d);
    host_idx = idx; host_wdata = d; host_wr = 1; step(); host_wr = 0;
  endtask

  task automatic rd_chk(input string req, input [7:0] idx, input [7:0] exp);
    host_idx = idx; #1; chk(req, host_rdata, exp);
  endtask

  task automatic fall_sys(input [2:0] c);
    {cmp_red, cmp_grn, cmp_blu} = c;
    sys_blank = 1; step(); sys_blank = 0; step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    cur_req = "R1";
    rd_chk("R1", 8'h3A, 8'h00);
    chk("R1", {7'b0, sense_n}, 8'h01);

    cur_req = "R2";
    for (int p = 0; p < 8; p++) begin
      fall_sys(p[2:0]);
      rd_chk("R2", 8'h3A, {5'b0, p[2:0]});
      chk("R3", {7'b0, sense_n}, {7'b0, p == 0});
    end

    cur_req = "R4";
    fall_sys(3'b010);
    cmp_red = 1; cmp_blu = 1; step(); step();
    sys_blank = 1; {cmp_red, cmp_grn, cmp_blu} = 3'b000; step();
    cmp_red = 1; step(); step();
    rd_chk("R4", 8'h3A, 8'h02);
    chk("R4", {7'b0, sense_n}, 8'h00);
    sys_blank = 0; step();
    rd_chk("R4", 8'h3A, 8'h04);

    cur_req = "R5";
    {cmp_red, cmp_grn, cmp_blu} = 3'b011;
    vga_blank = 1; step(); vga_blank = 0; step();
    rd_chk("R5", 8'h3A, 8'h04);
    blank_sel = 1; step();
    vga_blank = 1; step(); vga_blank = 0; step();
    rd_chk("R5", 8'h3A, 8'h03);
    {cmp_red, cmp_grn, cmp_blu} = 3'b000;
    sys_blank = 1; step(); sys_blank = 0; step();
    rd_chk("R5", 8'h3A, 8'h03);
    blank_sel = 0; step();

    cur_req = "R7";
    wr(8'h3A, 8'h7F);
    rd_chk("R7", 8'h3A, 8'h03);

    cur_req = "R8";
    wr(8'h3F, 8'hFF);
    rd_chk("R8", 8'h3F, 8'h26);
    rd_chk("R8", 8'h3A, 8'h03);

    cur_req = "R9";
    rd_chk("R9", 8'h00, 8'h00);
    rd_chk("R9", 8'h3B, 8'h00);
    rd_chk("R9", 8'hFF, 8'h00);

    cur_req = "R6";
    wr(8'h3A, 8'h80);
    rd_chk("R6", 8'h3A, 8'h80);
    chk("R6", {7'b0, sense_n}, 8'h01);
    fall_sys(3'b111);
    rd_chk("R6", 8'h3A, 8'h80);
    chk("R6", {7'b0, sense_n}, 8'h01);
    wr(8'h3A, 8'h00);
    rd_chk("R6", 8'h3A, 8'h00);
    chk("R6", {7'b0, sense_n}, 8'h01);
    fall_sys(3'b100);
    rd_chk("R6", 8'h3A, 8'h04);
    chk("R6", {7'b0, sense_n}, 8'h00);

    cur_req = "R10";
    {cmp_red, cmp_grn, cmp_blu} = 3'b111;
    sys_blank = 1; step();
    sys_blank = 0; wr(8'h3A, 8'h80);
    rd_chk("R10", 8'h3A, 8'h80);
    chk("R10", {7'b0, sense_n}, 8'h01);
    sys_blank = 1; step();
    sys_blank = 0; wr(8'h3A, 8'h00);
    rd_chk("R10", 8'h3A, 8'h00);
    chk("R10", {7'b0, sense_n}, 8'h01);
    fall_sys(3'b001);
    rd_chk("R10", 8'h3A, 8'h01);

    cur_req = "R4";
    for (int k = 0; k < 40; k++) begin
      sys_blank = (k % 3) == 0;
      {cmp_red, cmp_grn, cmp_blu} = 3'(k * 5);
      host_idx = (k % 4 == 0) ? 8'h3F : 8'h3A;
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule